// File: doc/BRIEF.md
# Interrupt controller command decoder

This block is the byte-wide programming front end of an eight-line priority interrupt controller. A host reaches it through a two-address register port. Writes program the controller. A short initialization sequence sets the vector base, the cascade and single options, and the fully nested and automatic end-of-interrupt modes. Later command writes retire in-service lines, move the rotating priority base, pick the register returned by reads and arm a poll. Reads return the pending-request, in-service or mask register, or a one-shot poll result.

The block holds the pending (IRR), in-service (ISR) and mask (IMR) registers, together with the priority base. It feeds these to a small resolver that finds the winning line. Requests are edge captured from `irq_in`. A one-cycle `inta` strobe acknowledges the current winner while `vector_out` presents the vector for it. Rank is measured as `(line - base) mod 8`, where rank 0 is the most urgent.

Top module: `pic_cmd_ctrl`

## Requirements
- R1: After synchronous reset, IRR, ISR, IMR, the priority base, the init step and every mode bit are zero. `int_out` is low, and reads of both addresses return 0x00.
- R2: A low-to-high change on `irq_in[n]` sets IRR bit n one cycle later. A line that stays high sets it only once.
- R3: A write to address 0 with bit 4 set is an initialization start. It clears IRR, ISR, IMR, the base, rotate-on-auto-EOI, special mask, poll, the read select (back to IRR), the vector base and both ICW4 mode bits. It records "mode word needed" from bit 0 and "single" from bit 1, and enters step 1. Bit 3 has no effect.
- R4: Address-1 writes follow the init step. Step 0 loads IMR. Step 1 stores bits 7:3 as the vector base, then goes to step 2 if not single, else to step 3 if the mode word is needed, else to step 0. Step 2 goes to step 3 if the mode word is needed, else to step 0. Step 3 takes fully nested mode from bit 4 and automatic EOI from bit 1, then goes to step 0. Steps 1 to 3 leave IMR unchanged.
- R5: The winner is the pending unmasked line of lowest rank. It is signalled on `int_out` only if no considered ISR line has an equal or lower rank. In fully nested mode ISR bit 2 is not considered. With special mask on, ISR bits of masked lines are not considered.
- R6: `vector_out` is {vector base, winner}, or {vector base, 7} with no winner. An `inta` cycle with a winner clears that line's IRR bit. It sets the line's ISR bit unless automatic EOI is on. In that case, if rotate-on-auto-EOI is set, the base becomes winner+1 instead.
- R7: An address-0 write with bit 4 and bit 3 clear carries a command in bits 7:5. Code 001 clears the lowest-rank ISR bit. Code 101 does the same and sets the base to that line+1. With ISR empty, both change nothing.
- R8: Code 011 clears ISR bit n = bits 2:0. Code 111 clears bit n and sets the base to n+1. Code 110 sets the base to n+1 only. Code 000 clears and code 100 sets rotate-on-auto-EOI. Code 010 does nothing.
- R9: An address-0 write with bit 4 clear and bit 3 set is a read/mode command. When bit 1 is set, the read select takes bit 0 (1 = ISR, 0 = IRR). When bit 6 is set, special mask takes bit 5. Bit 2 arms a poll.
- R10: Without an armed poll, address 0 reads return ISR or IRR as selected, and address 1 reads return IMR.
- R11: With a poll armed, a read of either address returns 0x80 | winner, or 0x07 with no winner. That read cycle clears the winner's IRR and ISR bits and disarms the poll.
- R12: A rising edge on a line in the same cycle as an acknowledge, poll or initialization start that clears the line's IRR bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on poll) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Request lines, edge captured |
| inta | input | 1 | Acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Vector of the current winner |

## Verification
Request capture and the clearing actions meet in the same cycle. A line can rise just as an acknowledge, a poll read or an initialization start removes its IRR bit. Also, a command write can land in the same cycle as an acknowledge that uses the pre-write winner and mode bits. The bench provokes these by dropping a pending line and raising it again in the very cycle of `inta`. A random phase also mixes writes, acknowledges and line toggles freely. A behavioural model applies the written order (writes, then poll, then acknowledge, then new edges) and is compared with `rdata`, `int_out` and `vector_out` on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int N_LINES = 8;
    localparam int LW      = $clog2(N_LINES);
    localparam int DW      = 8;
    localparam int VBW     = DW - LW;

    typedef logic [N_LINES-1:0] line_vec_t;
    typedef logic [LW-1:0]      line_t;
    typedef logic [VBW-1:0]     vbase_t;

    typedef enum logic [1:0] {
        STEP_READY = 2'd0,
        STEP_BASE  = 2'd1,
        STEP_CASC  = 2'd2,
        STEP_MODE  = 2'd3
    } init_step_t;

    typedef enum logic [2:0] {
        OP_AEOI_ROT_OFF = 3'd0,
        OP_EOI_TOP      = 3'd1,
        OP_NONE         = 3'd2,
        OP_EOI_LINE     = 3'd3,
        OP_AEOI_ROT_ON  = 3'd4,
        OP_EOI_TOP_ROT  = 3'd5,
        OP_BASE_SET     = 3'd6,
        OP_EOI_LINE_ROT = 3'd7
    } op2_t;

    typedef struct packed {
        logic            start;
        logic            cmd;
        logic            rdmode;
        logic            cfg;
        op2_t            op;
        line_t           line;
        logic            need_mode;
        logic            single;
        logic            poll_req;
        logic            sel_upd;
        logic            sel_isr;
        logic            smm_upd;
        logic            smm_val;
        logic [DW-1:0]   data;
    } cmd_t;

    typedef struct packed {
        logic  vld;
        line_t line;
    } pick_t;

    function automatic line_t rank_of(line_t l, line_t base);
        return line_t'(l - base);
    endfunction

    function automatic pick_t first_by_rank(line_vec_t m, line_t base);
        pick_t r;
        r = '0;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            line_t l;
            l = line_t'(base + line_t'(k));
            if (m[l]) begin
                r.vld  = 1'b1;
                r.line = l;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_pkg::*;
(
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output cmd_t          cmd
);
    logic a0_wr;

    always_comb begin
        a0_wr          = wr_en && !addr;
        cmd.start      = a0_wr && wdata[4];
        cmd.rdmode     = a0_wr && !wdata[4] && wdata[3];
        cmd.cmd        = a0_wr && !wdata[4] && !wdata[3];
        cmd.cfg        = wr_en && addr;
        cmd.op         = op2_t'(wdata[7:5]);
        cmd.line       = wdata[LW-1:0];
        cmd.need_mode  = wdata[0];
        cmd.single     = wdata[1];
        cmd.poll_req   = wdata[2];
        cmd.sel_upd    = wdata[1];
        cmd.sel_isr    = wdata[0];
        cmd.smm_upd    = wdata[6];
        cmd.smm_val    = wdata[5];
        cmd.data       = wdata;
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       need_mode_in,
    input  logic       single_in,
    input  logic       cfg_wr,
    input  vbase_t     vbase_in,
    input  logic       sfnm_in,
    input  logic       aeoi_in,
    output init_step_t step,
    output vbase_t     vbase,
    output logic       sfnm,
    output logic       aeoi,
    output logic       imr_wr
);
    logic single_q, need_mode_q;

    assign imr_wr = cfg_wr && (step == STEP_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            step        <= STEP_READY;
            single_q    <= 1'b0;
            need_mode_q <= 1'b0;
            vbase       <= '0;
            sfnm        <= 1'b0;
            aeoi        <= 1'b0;
        end else if (start) begin
            step        <= STEP_BASE;
            single_q    <= single_in;
            need_mode_q <= need_mode_in;
            vbase       <= '0;
            sfnm        <= 1'b0;
            aeoi        <= 1'b0;
        end else if (cfg_wr) begin
            unique case (step)
                STEP_READY: ;
                STEP_BASE: begin
                    vbase <= vbase_in;
                    if (!single_q)        step <= STEP_CASC;
                    else if (need_mode_q) step <= STEP_MODE;
                    else                  step <= STEP_READY;
                end
                STEP_CASC: step <= need_mode_q ? STEP_MODE : STEP_READY;
                STEP_MODE: begin
                    sfnm <= sfnm_in;
                    aeoi <= aeoi_in;
                    step <= STEP_READY;
                end
                default: step <= STEP_READY;
            endcase
        end
    end

    assert_step_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> (step == STEP_BASE && !sfnm && !aeoi));

    assert_mode_returns_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !start && step == STEP_MODE) |=> (step == STEP_READY));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  line_vec_t irr,
    input  line_vec_t imr,
    input  line_vec_t isr,
    input  line_t     base,
    input  logic      sfnm,
    input  logic      smm,
    output pick_t     win,
    output pick_t     top_isr
);
    line_vec_t req, isr_eff;
    pick_t     cand, cur;

    always_comb begin
        req     = irr & ~imr;
        isr_eff = isr;
        if (sfnm) isr_eff[CASC_LINE] = 1'b0;
        if (smm)  isr_eff = isr_eff & ~imr;
        cand    = first_by_rank(req, base);
        cur     = first_by_rank(isr_eff, base);
        top_isr = first_by_rank(isr, base);
        win     = '0;
        if (cand.vld && (!cur.vld || rank_of(cand.line, base) < rank_of(cur.line, base)))
            win = cand;
    end
endmodule

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
    import pic_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N_LINES-1:0] irq_in,
    input  logic          inta,
    output logic          int_out,
    output logic [DW-1:0] vector_out
);
    cmd_t       cmd;
    init_step_t step;
    vbase_t     vbase;
    logic       sfnm, aeoi, imr_wr;
    pick_t      win, top_isr;

    line_vec_t irr_q, isr_q, imr_q, prev_q;
    line_t     base_q;
    logic      rot_q, sel_q, smm_q, poll_q;

    line_vec_t irr_n, isr_n, imr_n;
    line_t     base_n;
    logic      rot_n, sel_n, smm_n, poll_n;

    pic_cmd_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    pic_init_seq u_init (
        .clk          (clk),
        .rst          (rst),
        .start        (cmd.start),
        .need_mode_in (cmd.need_mode),
        .single_in    (cmd.single),
        .cfg_wr       (cmd.cfg),
        .vbase_in     (cmd.data[DW-1:LW]),
        .sfnm_in      (cmd.data[4]),
        .aeoi_in      (cmd.data[1]),
        .step         (step),
        .vbase        (vbase),
        .sfnm         (sfnm),
        .aeoi         (aeoi),
        .imr_wr       (imr_wr)
    );

    pic_resolver #(.CASC_LINE(CASC_LINE)) u_res (
        .irr     (irr_q),
        .imr     (imr_q),
        .isr     (isr_q),
        .base    (base_q),
        .sfnm    (sfnm),
        .smm     (smm_q),
        .win     (win),
        .top_isr (top_isr)
    );

    assign int_out    = win.vld;
    assign vector_out = {vbase, win.vld ? win.line : line_t'(N_LINES - 1)};

    always_comb begin
        if (poll_q)
            rdata = win.vld ? {1'b1, {(DW-1-LW){1'b0}}, win.line} : DW'(N_LINES - 1);
        else if (addr)
            rdata = imr_q;
        else
            rdata = sel_q ? isr_q : irr_q;
    end

    always_comb begin
        irr_n  = irr_q;
        isr_n  = isr_q;
        imr_n  = imr_q;
        base_n = base_q;
        rot_n  = rot_q;
        sel_n  = sel_q;
        smm_n  = smm_q;
        poll_n = poll_q;
        if (cmd.start) begin
            irr_n  = '0;
            isr_n  = '0;
            imr_n  = '0;
            base_n = '0;
            rot_n  = 1'b0;
            sel_n  = 1'b0;
            smm_n  = 1'b0;
            poll_n = 1'b0;
        end else begin
            if (imr_wr) imr_n = cmd.data;
            if (cmd.rdmode) begin
                if (cmd.poll_req) poll_n = 1'b1;
                if (cmd.sel_upd)  sel_n  = cmd.sel_isr;
                if (cmd.smm_upd)  smm_n  = cmd.smm_val;
            end
            if (cmd.cmd) begin
                unique case (cmd.op)
                    OP_AEOI_ROT_OFF,
                    OP_AEOI_ROT_ON:  rot_n = cmd.op[2];
                    OP_EOI_TOP: begin
                        if (top_isr.vld) isr_n[top_isr.line] = 1'b0;
                    end
                    OP_EOI_TOP_ROT: begin
                        if (top_isr.vld) begin
                            isr_n[top_isr.line] = 1'b0;
                            base_n = line_t'(top_isr.line + 1'b1);
                        end
                    end
                    OP_EOI_LINE:     isr_n[cmd.line] = 1'b0;
                    OP_BASE_SET:     base_n = line_t'(cmd.line + 1'b1);
                    OP_EOI_LINE_ROT: begin
                        isr_n[cmd.line] = 1'b0;
                        base_n = line_t'(cmd.line + 1'b1);
                    end
                    default: ;
                endcase
            end
            if (rd_en && poll_q) begin
                poll_n = 1'b0;
                if (win.vld) begin
                    irr_n[win.line] = 1'b0;
                    isr_n[win.line] = 1'b0;
                end
            end
            if (inta && win.vld) begin
                irr_n[win.line] = 1'b0;
                if (aeoi) begin
                    if (rot_q) base_n = line_t'(win.line + 1'b1);
                end else begin
                    isr_n[win.line] = 1'b1;
                end
            end
        end
        irr_n = irr_n | (irq_in & ~prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            imr_q  <= '0;
            prev_q <= '0;
            base_q <= '0;
            rot_q  <= 1'b0;
            sel_q  <= 1'b0;
            smm_q  <= 1'b0;
            poll_q <= 1'b0;
        end else begin
            irr_q  <= irr_n;
            isr_q  <= isr_n;
            imr_q  <= imr_n;
            prev_q <= irq_in;
            base_q <= base_n;
            rot_q  <= rot_n;
            sel_q  <= sel_n;
            smm_q  <= smm_n;
            poll_q <= poll_n;
        end
    end

    assert_ack_marks_service_R6: assert property (@(posedge clk) disable iff (rst)
        (inta && win.vld && !aeoi && !wr_en && !rd_en) |=> isr_q[$past(win.line)]);

    assert_mask_held_in_init_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && step != STEP_READY) |=> $stable(imr_q));

    assert_poll_one_shot_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && poll_q && !wr_en) |=> !poll_q);

    assert_nested_block_R5: assert property (@(posedge clk) disable iff (rst)
        (win.vld && !sfnm && !smm_q) |-> !isr_q[win.line]);
endmodule

// File: tb/pic_cmd_ctrl_bench.sv
module pic_cmd_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
    logic [7:0] wdata = 8'h00, irq = 8'h00;
    logic [7:0] rdata, vector_out;
    logic       int_out;

    int vectors = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    logic [7:0] m_irr, m_isr, m_imr, m_prev;
    int m_base, m_step, m_vbase;
    bit m_rot, m_sel, m_smm, m_poll, m_single, m_need, m_sfnm, m_aeoi;

    always #4 clk = ~clk;

    pic_cmd_ctrl u_pic_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq), .inta(inta),
        .int_out(int_out), .vector_out(vector_out)
    );

    function automatic int rank(int l);
        return (l - m_base + 8) % 8;
    endfunction

    function automatic int pick(logic [7:0] m);
        for (int k = 0; k < 8; k++)
            if (m[(m_base + k) % 8]) return (m_base + k) % 8;
        return -1;
    endfunction

    function automatic int m_winner();
        logic [7:0] ie;
        int w, c;
        w = pick(m_irr & ~m_imr);
        if (w < 0) return -1;
        ie = m_isr;
        if (m_sfnm) ie[2] = 1'b0;
        if (m_smm) ie = ie & ~m_imr;
        c = pick(ie);
        if (c < 0 || rank(w) < rank(c)) return w;
        return -1;
    endfunction

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0;
        m_base = 0; m_step = 0; m_vbase = 0;
        m_rot = 0; m_sel = 0; m_smm = 0; m_poll = 0;
        m_single = 0; m_need = 0; m_sfnm = 0; m_aeoi = 0;
    endtask

    task automatic model_update();
        int w, top, n;
        bit o_aeoi, o_rot;
        logic [7:0] edges;
        w = m_winner();
        top = pick(m_isr);
        o_aeoi = m_aeoi;
        o_rot = m_rot;
        edges = irq & ~m_prev;
        n = wdata & 7;
        if (wr_en && !addr && wdata[4]) begin
            m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0;
            m_rot = 0; m_sel = 0; m_smm = 0; m_poll = 0;
            m_step = 1; m_single = wdata[1]; m_need = wdata[0];
            m_vbase = 0; m_sfnm = 0; m_aeoi = 0;
        end else begin
            if (wr_en && addr) begin
                case (m_step)
                    0: m_imr = wdata;
                    1: begin
                        m_vbase = wdata >> 3;
                        m_step = !m_single ? 2 : (m_need ? 3 : 0);
                    end
                    2: m_step = m_need ? 3 : 0;
                    default: begin
                        m_sfnm = wdata[4]; m_aeoi = wdata[1]; m_step = 0;
                    end
                endcase
            end
            if (wr_en && !addr && wdata[3]) begin
                if (wdata[2]) m_poll = 1;
                if (wdata[1]) m_sel = wdata[0];
                if (wdata[6]) m_smm = wdata[5];
            end
            if (wr_en && !addr && !wdata[3]) begin
                case (wdata[7:5])
                    0, 4: m_rot = wdata[7];
                    1: if (top >= 0) m_isr[top] = 0;
                    5: if (top >= 0) begin m_isr[top] = 0; m_base = (top + 1) % 8; end
                    3: m_isr[n] = 0;
                    6: m_base = (n + 1) % 8;
                    7: begin m_isr[n] = 0; m_base = (n + 1) % 8; end
                    default: ;
                endcase
            end
            if (rd_en && m_poll) begin
                m_poll = 0;
                if (w >= 0) begin m_irr[w] = 0; m_isr[w] = 0; end
            end
            if (inta && w >= 0) begin
                m_irr[w] = 0;
                if (o_aeoi) begin
                    if (o_rot) m_base = (w + 1) % 8;
                end else m_isr[w] = 1;
            end
        end
        m_irr = m_irr | edges;
        m_prev = irq;
    endtask

    task automatic cmp(string tag, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        int w;
        logic [7:0] er;
        #1;
        w = m_winner();
        if (m_poll) er = (w >= 0) ? 8'(128 + w) : 8'h07;
        else if (addr) er = m_imr;
        else er = m_sel ? m_isr : m_irr;
        cmp({cur_req, " rdata"}, rdata, er);
        cmp({cur_req, " int_out"}, {7'd0, int_out}, {7'd0, w >= 0});
        cmp({cur_req, " vector"}, vector_out, 8'(m_vbase * 8 + ((w >= 0) ? w : 7)));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0; addr = 0;
    endtask

    task automatic rd(logic a, logic [7:0] exp, string tag);
        addr = a; rd_en = 1; #1;
        cmp({tag, " read"}, rdata, exp);
        tick(); rd_en = 0; addr = 0;
    endtask

    task automatic ack();
        inta = 1; tick(); inta = 0;
    endtask

    task automatic lines(logic [7:0] v);
        irq = v; tick();
    endtask

    task automatic expect_vec(logic i, logic [7:0] v, string tag);
        #1;
        cmp({tag, " int"}, {7'd0, int_out}, {7'd0, i});
        if (i) cmp({tag, " vec"}, vector_out, v);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        cur_req = "R1";
        rd(1, 8'h00, "R1"); rd(0, 8'h00, "R1");
        expect_vec(0, 0, "R1");
        // R3 start with bit 3 set, single, mode word; R4 sequence
        cur_req = "R3";
        wr(0, 8'h1B); wr(1, 8'h40); wr(1, 8'h00);
        cur_req = "R4";
        wr(1, 8'hF0); rd(1, 8'hF0, "R4");
        cur_req = "R3";
        wr(0, 8'h11); rd(1, 8'h00, "R3");
        cur_req = "R4";
        wr(1, 8'h48); wr(1, 8'h55); wr(1, 8'h00);
        rd(1, 8'h00, "R4");
        wr(1, 8'h0F); rd(1, 8'h0F, "R4"); wr(1, 8'h00);
        // R2 edge capture
        cur_req = "R2";
        lines(8'h08); rd(0, 8'h08, "R2");
        expect_vec(1, 8'h4B, "R2");
        // R6 acknowledge
        cur_req = "R6";
        ack();
        cur_req = "R9";
        wr(0, 8'h0B);
        cur_req = "R10";
        rd(0, 8'h08, "R10");
        expect_vec(0, 0, "R6");
        // R5 nesting
        cur_req = "R5";
        lines(8'h28); expect_vec(0, 0, "R5");
        lines(8'h2A); expect_vec(1, 8'h49, "R5");
        ack(); rd(0, 8'h0A, "R6");
        // R7 / R8 end of interrupt commands
        cur_req = "R7";
        wr(0, 8'h20); rd(0, 8'h08, "R7");
        cur_req = "R8";
        wr(0, 8'h63); expect_vec(1, 8'h4D, "R8");
        ack();
        cur_req = "R7";
        wr(0, 8'hA0); rd(0, 8'h00, "R7");
        lines(8'h00); lines(8'h81); expect_vec(1, 8'h4F, "R7");
        ack();
        cur_req = "R8";
        wr(0, 8'hC1); wr(0, 8'h67); wr(0, 8'h40);
        lines(8'h89); expect_vec(1, 8'h4B, "R8");
        wr(0, 8'hE3); expect_vec(1, 8'h48, "R8");
        // R11 poll
        cur_req = "R11";
        wr(0, 8'h0C); rd(0, 8'h80, "R11");
        wr(0, 8'h0C); rd(1, 8'h83, "R11");
        wr(0, 8'h0C); rd(0, 8'h07, "R11");
        rd(0, 8'h00, "R10");
        // R9 special mask
        cur_req = "R9";
        lines(8'h00); lines(8'h01); ack();
        wr(1, 8'h01); lines(8'h03); expect_vec(0, 0, "R5");
        wr(0, 8'h68); expect_vec(1, 8'h49, "R9");
        wr(0, 8'h48); expect_vec(0, 0, "R9");
        wr(0, 8'h60); ack(); wr(0, 8'h61); wr(1, 8'h00);
        // R6 automatic EOI with rotation
        cur_req = "R6";
        lines(8'h00);
        wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h02);
        lines(8'h10); expect_vec(1, 8'h24, "R6");
        ack(); wr(0, 8'h0B); rd(0, 8'h00, "R6");
        wr(0, 8'h80); lines(8'h30); ack();
        lines(8'h00); lines(8'h41); expect_vec(1, 8'h26, "R6");
        // R5 fully nested mode
        cur_req = "R5";
        lines(8'h00);
        wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h10);
        lines(8'h04); ack(); lines(8'h00); lines(8'h04);
        expect_vec(1, 8'h22, "R5");
        // R12 edge in the acknowledge cycle
        cur_req = "R12";
        lines(8'h00);
        wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h00);
        lines(8'h10); lines(8'h00);
        irq = 8'h10; ack();
        rd(0, 8'h10, "R12");
        expect_vec(0, 0, "R12");
        // mixed random traffic, R12 collisions included
        cur_req = "rand R12";
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 3) == 0) irq[$urandom_range(0, 7)] ^= 1'b1;
            if (r < 20) begin
                addr = $urandom_range(0, 1); wdata = 8'($urandom); wr_en = 1;
                if ($urandom_range(0, 4) == 0) inta = 1;
            end else if (r < 32) begin
                addr = $urandom_range(0, 1); rd_en = 1;
            end else if (r < 50) inta = 1;
            tick();
            wr_en = 0; rd_en = 0; inta = 0; addr = 0;
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule